// File: doc/BRIEF.md
# Peripheral Register Bit-Field Accessor

This unit runs the two field instructions of a small control core against a word-addressed peripheral register bus. A field read fetches the addressed 32-bit register, isolates the bits between a low and a high index taken from the instruction, and returns them right-aligned and zero-padded for the core to store into R0. The result is at most 16 bits wide. A field write carries an 8-bit immediate. The unit reads the target register, replaces only the bits between the two indices with the immediate shifted up to the low index, and writes the merged word back. Every bit outside the field keeps its old value.

The core raises `reqValid` for one or more cycles with the opcode fields. The unit accepts the request when it is idle, runs a fixed-length sequence, and pulses `done`. A read costs 4 cycles and a write costs 8 cycles, whatever the field. Register addresses are word indices and go to the bus unchanged. An index pair that is inverted, or that describes a field wider than the instruction allows, is clamped to the widest legal field starting at the low index, and `fieldErr` is flagged.

Top module: `regfield_access`

## Requirements
- R1: After reset, `done`, `busy`, `busRdEn`, `busWrEn`, `r0WriteEn` and `fieldErr` are all low.
- R2: A request is accepted on a rising edge where `reqValid` is high and `busy` is low. `busRdEn` is high for exactly the first cycle after acceptance, with `busAddr` equal to `reqAddr`. Read data is expected on `busRdata` one cycle after `busRdEn`.
- R3: For a read (`reqIsWrite`=0), `done` and `r0WriteEn` are high together in the 4th cycle after acceptance. In that cycle `rdResult` equals register bits [High:Low] shifted down to bit 0, with all upper bits zero.
- R4: A read field wider than 16 bits, or one with High < Low, returns the 16 bits starting at Low. Bits at index 32 and above read as zero. `fieldErr` is high with `done`.
- R5: For a write (`reqIsWrite`=1), `busWrEn` is high for exactly the 3rd cycle after acceptance, to the same `busAddr`. `done` is high in the 8th cycle, and `r0WriteEn` stays low.
- R6: The written word equals the old word with bits [High:Low] replaced by the low bits of `reqData`. All other bits are unchanged.
- R7: A write field wider than 8 bits, or one with High < Low, is clamped to the 8 bits starting at Low, truncated at bit 31. `fieldErr` is high with `done`.
- R8: `done` is a single-cycle pulse. While `busy` is high, `reqValid` is ignored: there are no extra bus accesses and the register contents are unchanged.
- R9: For a field whose High >= Low and whose width is within the limit, `fieldErr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request strobe |
| reqIsWrite | input | 1 | 1 = field write, 0 = field read |
| reqAddr | input | ADDR_W (10) | Register word address |
| reqHigh | input | 5 | Upper bit index of field |
| reqLow | input | 5 | Lower bit index of field |
| reqData | input | 8 | Write immediate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| r0WriteEn | output | 1 | Store `rdResult` to R0 |
| rdResult | output | 16 | Zero-extended read field |
| fieldErr | output | 1 | Index pair was clamped (valid with `done`) |
| busAddr | output | ADDR_W (10) | Bus word address |
| busRdEn | output | 1 | Bus read strobe |
| busWrEn | output | 1 | Bus write strobe |
| busWdata | output | 32 | Bus write data |
| busRdata | input | 32 | Bus read data, one cycle after `busRdEn` |

## Verification
The bench targets field edges: a single bit, a field that touches bit 31, and a field exactly at the width limit. A mask that is one bit off would corrupt a neighbouring bit, and the memory comparison would catch it. Inverted and oversize index pairs check the clamp. A unit that masked only with the raw indices would either write more than 8 bits or return garbage above bit 15. A request held high through a whole operation checks that a busy unit does not start a second bus access or retrigger `done`. The exact done cycle is checked for both operation types, so a unit with the wrong cycle padding is caught.

// File: rtl/regfield_pkg.sv
package regfield_pkg;
  localparam int WORD_W = 32;
  localparam int RD_MAX = 16;
  localparam int WR_MAX = 8;
  localparam int RD_CYCLES = 4;
  localparam int WR_CYCLES = 8;

  // Control-to-datapath strobes
  typedef struct packed {
    logic accept;
    logic rdStrobe;
    logic capStrobe;
    logic wrStrobe;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/regfield_ctrl.sv
module regfield_ctrl
  import regfield_pkg::*;
#(
  parameter int RdCycles = RD_CYCLES,
  parameter int WrCycles = WR_CYCLES
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqIsWrite,
  output strobe_t strobes,
  output logic    busy
);
  localparam int CNT_W = $clog2(WrCycles + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RdCycles);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WrCycles);

  logic             active;
  logic             opWrite;
  logic [CNT_W-1:0] cnt;
  logic             lastCycle;

  assign lastCycle = active && (cnt == (opWrite ? WR_LAST : RD_LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      opWrite <= 1'b0;
      cnt     <= '0;
    end else if (!active) begin
      if (reqValid) begin
        active  <= 1'b1;
        opWrite <= reqIsWrite;
        cnt     <= CNT_W'(1);
      end
    end else if (lastCycle) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.accept    = reqValid && !active;
    strobes.rdStrobe  = active && (cnt == CNT_W'(1));
    strobes.capStrobe = active && (cnt == CNT_W'(2));
    strobes.wrStrobe  = active && opWrite && (cnt == CNT_W'(3));
    strobes.finish    = lastCycle;
  end

  assign busy = active;
endmodule

// File: rtl/regfield_dp.sv
module regfield_dp
  import regfield_pkg::*;
#(
  parameter int AddrW = 10,
  parameter int WordW = WORD_W,
  parameter int RdMax = RD_MAX,
  parameter int WrMax = WR_MAX
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              reqIsWrite,
  input  logic [AddrW-1:0]  reqAddr,
  input  logic [$clog2(WordW)-1:0] reqHigh,
  input  logic [$clog2(WordW)-1:0] reqLow,
  input  logic [WrMax-1:0]  reqData,
  input  logic [WordW-1:0]  busRdata,
  output logic [AddrW-1:0]  busAddr,
  output logic [WordW-1:0]  busWdata,
  output logic [RdMax-1:0]  fieldValue,
  output logic              errFlag,
  output logic              isWrite
);
  localparam int IDX_W = $clog2(WordW);
  localparam int WID_W = IDX_W + 1;

  logic [WID_W-1:0] spanMax, rawWidth, nextWidth;
  logic             nextErr;

  // Width of the requested field, clamped to the limit for this op type
  always_comb begin
    spanMax   = reqIsWrite ? WID_W'(WrMax) : WID_W'(RdMax);
    rawWidth  = {1'b0, reqHigh} - {1'b0, reqLow} + WID_W'(1);
    nextErr   = (reqHigh < reqLow) || (rawWidth > spanMax);
    nextWidth = nextErr ? spanMax : rawWidth;
  end

  logic [AddrW-1:0] addrQ;
  logic [IDX_W-1:0] lowQ;
  logic [WID_W-1:0] widthQ;
  logic [WrMax-1:0] dataQ;
  logic [WordW-1:0] oldQ;
  logic             errQ, isWrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      lowQ   <= '0;
      widthQ <= '0;
      dataQ  <= '0;
      errQ   <= 1'b0;
      isWrQ  <= 1'b0;
      oldQ   <= '0;
    end else begin
      if (strobes.accept) begin
        addrQ  <= reqAddr;
        lowQ   <= reqLow;
        widthQ <= nextWidth;
        dataQ  <= reqData;
        errQ   <= nextErr;
        isWrQ  <= reqIsWrite;
      end
      if (strobes.capStrobe) oldQ <= busRdata;
    end
  end

  logic [WordW-1:0] widthMask, fieldMask, insertBits;

  always_comb begin
    widthMask  = (WordW'(1) << widthQ) - WordW'(1);
    fieldMask  = widthMask << lowQ;
    insertBits = (WordW'(dataQ) << lowQ) & fieldMask;
    busWdata   = (oldQ & ~fieldMask) | insertBits;
    fieldValue = RdMax'((oldQ >> lowQ) & widthMask);
  end

  assign busAddr = addrQ;
  assign errFlag = errQ;
  assign isWrite = isWrQ;
endmodule

// File: rtl/regfield_access.sv
module regfield_access
  import regfield_pkg::*;
#(
  parameter int AddrW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsWrite,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [4:0]       reqHigh,
  input  logic [4:0]       reqLow,
  input  logic [7:0]       reqData,
  output logic             busy,
  output logic             done,
  output logic             r0WriteEn,
  output logic [15:0]      rdResult,
  output logic             fieldErr,
  output logic [AddrW-1:0] busAddr,
  output logic             busRdEn,
  output logic             busWrEn,
  output logic [31:0]      busWdata,
  input  logic [31:0]      busRdata
);
  strobe_t     strobes;
  logic [15:0] fieldValue;
  logic        errFlag;
  logic        isWrite;

  regfield_ctrl #(.RdCycles(RD_CYCLES), .WrCycles(WR_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .strobes(strobes), .busy(busy)
  );

  regfield_dp #(.AddrW(AddrW), .WordW(32), .RdMax(16), .WrMax(8)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqIsWrite(reqIsWrite),
    .reqAddr(reqAddr), .reqHigh(reqHigh), .reqLow(reqLow), .reqData(reqData),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata),
    .fieldValue(fieldValue), .errFlag(errFlag), .isWrite(isWrite)
  );

  assign busRdEn   = strobes.rdStrobe;
  assign busWrEn   = strobes.wrStrobe;
  assign done      = strobes.finish;
  assign r0WriteEn = strobes.finish && !isWrite;
  assign rdResult  = r0WriteEn ? fieldValue : '0;
  assign fieldErr  = strobes.finish && errFlag;
endmodule

// File: rtl/regfield_access_chk.sv
module regfield_access_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic r0WriteEn,
  input logic fieldErr,
  input logic busRdEn,
  input logic busWrEn
);
  // R8: completion is a one-cycle pulse and ends the operation
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  // R2: a bus read opens a sequence, so the unit was idle just before
  assert_read_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> (busy && !$past(busy)));
  // R5: write-back follows the bus read by two cycles
  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> $past(busRdEn, 2));
  // R3: result store only in the completion cycle
  assert_r0_with_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    r0WriteEn |-> done);
  // R7: error indication only with completion
  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    fieldErr |-> done);
  // R1: no bus strobe outside an operation
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busRdEn && !busWrEn && !done));
endmodule

bind regfield_access regfield_access_chk i_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .r0WriteEn(r0WriteEn),
  .fieldErr(fieldErr), .busRdEn(busRdEn), .busWrEn(busWrEn)
);

// File: tb/test_regfield_access.sv
module test_regfield_access;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIsWrite = 1'b0;
  logic [9:0]  reqAddr = '0;
  logic [4:0]  reqHigh = '0, reqLow = '0;
  logic [7:0]  reqData = '0;
  logic        busy, done, r0WriteEn, fieldErr, busRdEn, busWrEn;
  logic [15:0] rdResult;
  logic [9:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic [31:0] mem [16];
  int checks = 0, errors = 0;
  int rdCount = 0, wrCount = 0;

  always #2.5 clk = ~clk;

  regfield_access i_regfield_access (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsWrite(reqIsWrite),
    .reqAddr(reqAddr), .reqHigh(reqHigh), .reqLow(reqLow), .reqData(reqData),
    .busy(busy), .done(done), .r0WriteEn(r0WriteEn), .rdResult(rdResult),
    .fieldErr(fieldErr), .busAddr(busAddr), .busRdEn(busRdEn),
    .busWrEn(busWrEn), .busWdata(busWdata), .busRdata(busRdata)
  );

  // Register bank model: read data one cycle after the strobe
  always @(posedge clk) begin
    if (busRdEn) begin busRdata <= mem[busAddr[3:0]]; rdCount++; end
    if (busWrEn) begin mem[busAddr[3:0]] <= busWdata; wrCount++; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int expWidth(int hi, int lo, int mx);
    if (hi < lo || hi - lo + 1 > mx) return mx;
    return hi - lo + 1;
  endfunction

  function automatic bit expErr(int hi, int lo, int mx);
    return (hi < lo) || (hi - lo + 1 > mx);
  endfunction

  function automatic logic [15:0] expRead(logic [31:0] w, int hi, int lo);
    longint unsigned m = (64'd1 << expWidth(hi, lo, 16)) - 1;
    return 16'((longint'(w) >> lo) & m);
  endfunction

  function automatic logic [31:0] expWrite(logic [31:0] w, int hi, int lo, logic [7:0] d);
    longint unsigned m = ((64'd1 << expWidth(hi, lo, 8)) - 1) << lo;
    logic [31:0] m32 = 32'(m);
    return (w & ~m32) | (32'(longint'(d) << lo) & m32);
  endfunction

  // Issue one operation; if hold, keep reqValid high (with a different target) while busy
  task automatic runOp(input bit wr, input int idx, input int hi, input int lo,
                       input logic [7:0] d, input bit hold);
    int n = wr ? 8 : 4;
    int doneAt = -1, doneCnt = 0, rdAt = -1, wrAt = -1;
    logic [15:0] res = '0;
    logic r0 = 1'b0, err = 1'b0;
    logic [9:0] rdAddr = '0, wrAddr = '0;
    logic [31:0] oldW = mem[idx];
    int rc0 = rdCount, wc0 = wrCount;
    logic [31:0] other = mem[(idx + 1) % 16];
    @(negedge clk);
    reqValid = 1'b1; reqIsWrite = wr; reqAddr = 10'(idx);
    reqHigh = 5'(hi); reqLow = 5'(lo); reqData = d;
    @(posedge clk);
    #1;
    if (hold) begin
      reqIsWrite = 1'b1; reqAddr = 10'((idx + 1) % 16); reqData = 8'hFF;
      reqHigh = 5'd7; reqLow = 5'd0;
    end else reqValid = 1'b0;
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      if (k == n) reqValid = 1'b0;
      if (busRdEn) begin if (rdAt < 0) rdAt = k; rdAddr = busAddr; end
      if (busWrEn) begin if (wrAt < 0) wrAt = k; wrAddr = busAddr; end
      if (done) begin doneCnt++; doneAt = k; res = rdResult; r0 = r0WriteEn; err = fieldErr; end
    end
    check(rdAt == 1 && rdAddr == 10'(idx), "R2", "bus read cycle/addr", 32'(rdAt), 32'd1);
    check(doneCnt == 1 && doneAt == n, wr ? "R5" : "R3", "done cycle", 32'(doneAt), 32'(n));
    check(rdCount - rc0 == 1 && wrCount - wc0 == (wr ? 1 : 0), "R8", "bus access count",
          32'(rdCount - rc0 + wrCount - wc0), 32'(wr ? 2 : 1));
    if (wr) begin
      check(wrAt == 3 && wrAddr == 10'(idx), "R5", "bus write cycle", 32'(wrAt), 32'd3);
      check(!r0, "R5", "r0WriteEn on write", 32'(r0), 32'd0);
      check(mem[idx] == expWrite(oldW, hi, lo, d), expErr(hi, lo, 8) ? "R7" : "R6",
            "merged word", mem[idx], expWrite(oldW, hi, lo, d));
      check(err == expErr(hi, lo, 8), expErr(hi, lo, 8) ? "R7" : "R9", "fieldErr",
            32'(err), 32'(expErr(hi, lo, 8)));
    end else begin
      check(wrAt < 0, "R3", "no write on read", 32'(wrAt), 32'hFFFFFFFF);
      check(r0 && res == expRead(oldW, hi, lo), expErr(hi, lo, 16) ? "R4" : "R3",
            "read field", 32'(res), 32'(expRead(oldW, hi, lo)));
      check(err == expErr(hi, lo, 16), expErr(hi, lo, 16) ? "R4" : "R9", "fieldErr",
            32'(err), 32'(expErr(hi, lo, 16)));
    end
    if (hold) check(mem[(idx + 1) % 16] == other, "R8", "held request ignored",
                    mem[(idx + 1) % 16], other);
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    for (int i = 0; i < 16; i++) mem[i] = 32'hA5000000 + 32'(i * 32'h01010101);
    mem[2] = 32'hABCD1234;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!done && !busy && !busRdEn && !busWrEn && !r0WriteEn && !fieldErr, "R1",
          "reset outputs", {26'd0, done, busy, busRdEn, busWrEn, r0WriteEn, fieldErr}, 32'd0);
    // Directed corners
    runOp(0, 2, 7, 4, 8'h00, 0);    // R3 nibble
    runOp(0, 2, 31, 16, 8'h00, 0);  // R3 16 bits at top
    runOp(0, 2, 31, 0, 8'h00, 0);   // R4 too wide
    runOp(0, 2, 3, 20, 8'h00, 0);   // R4 inverted, runs past bit 31
    runOp(1, 5, 7, 0, 8'h5A, 0);    // R6 full byte
    runOp(1, 5, 12, 12, 8'hFF, 0);  // R6 single bit
    runOp(1, 6, 31, 20, 8'hC3, 0);  // R7 too wide
    runOp(1, 7, 31, 28, 8'hFF, 0);  // R6 top edge
    runOp(1, 8, 2, 30, 8'hE7, 0);   // R7 inverted
    runOp(0, 9, 15, 8, 8'h00, 1);   // R8 held request, read
    runOp(1, 10, 11, 4, 8'h3C, 1);  // R8 held request, write
    for (int i = 0; i < 60; i++) begin
      runOp(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
            int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
            8'($urandom), 1'($urandom_range(0, 3) == 0));
    end
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule